// File: doc/BRIEF.md
# MSI Message Dispatcher

This block sits between a device's interrupt sources and the logic that issues memory writes on the bus. Each source drives one request line. A rising edge on a line asks for that vector to be signalled. The block reads the live settings of the message-interrupt capability registers: the enable bit, the multiple-message-enable field, the address words, the data word, and the per-vector mask and pending bits. From these it either builds a message beat or tells the register block to mark the vector pending.

A request for a vector whose mask bit is set is never sent. Instead the block pulses that vector's pending-set strobe. A request for an unmasked vector produces one message. The block pulses the pending-clear strobe for that vector in the cycle it loads the message. When software later clears a mask bit while the pending bit is set, the register block raises a resend request for that vector. The dispatcher treats a resend like a fresh source request.

Message beats leave through a valid/ready stream. A beat, once presented, stays valid with its address and data held until the consumer accepts it. Requests that arrive while the stream is stalled are held, one bit per vector. They are then sent lowest vector first.

Top module: `msi_dispatch`

## Requirements
- R1: Only a 0-to-1 transition on `irq_req[v]` creates a request. A line held high or a 1-to-0 transition produces no message and no pending strobe.
- R2: A request for vector v while `cfg_mask[v]` is 1 pulses `pend_set[v]` for exactly one cycle and produces no message.
- R3: An unmasked request for vector v pulses `pend_clr[v]` for one cycle, in the cycle just before `msg_valid` rises with that vector's message. At most one `pend_clr` bit is high at a time.
- R4: With `cfg_is64` at 1, `msg_addr` is {`cfg_addr_hi`, `cfg_addr_lo`}. With `cfg_is64` at 0, the upper 32 bits of `msg_addr` are zero and the lower 32 bits are `cfg_addr_lo`.
- R5: `msg_data[15:0]` is `cfg_data` with its low `cfg_mme` bits replaced by the low `cfg_mme` bits of the vector number (none replaced when `cfg_mme` is 0). `msg_data[31:16]` is zero.
- R6: While `cfg_enable` is 0, no new message is loaded. Source edges and resend requests seen in that time are discarded. Requests held when the enable drops are discarded.
- R7: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid`, `msg_addr` and `msg_data` stay unchanged. A beat already presented stays presented even if the enable drops. After reset `msg_valid`, `pend_set` and `pend_clr` are 0.
- R8: Requests that arrive while the output is stalled are held per vector and sent after the stall, none lost.
- R9: When several unmasked requests are held, the lowest-numbered vector is sent first.
- R10: `resend_req[v]` acts as a request only while `cfg_pending[v]` is 1. Otherwise it is ignored.
- R11: With the output idle and the vector unmasked, `msg_valid` rises on the clock edge after the edge that first samples the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 32 | Per-vector source request lines, edge sensitive |
| resend_req | input | 32 | Per-vector resend strobes from the register block |
| cfg_enable | input | 1 | Message interrupts enabled |
| cfg_is64 | input | 1 | 64-bit address layout in use |
| cfg_mme | input | 3 | Enabled message-count field (log2 of vectors) |
| cfg_addr_lo | input | 32 | Low message address word |
| cfg_addr_hi | input | 32 | High message address word |
| cfg_data | input | 16 | Message data word |
| cfg_mask | input | 32 | Per-vector mask bits |
| cfg_pending | input | 32 | Per-vector pending bits |
| msg_valid | output | 1 | Message beat valid |
| msg_ready | input | 1 | Consumer accepts the beat |
| msg_addr | output | 64 | Message write address |
| msg_data | output | 32 | Message write data |
| pend_set | output | 32 | One-cycle strobes to set pending bits |
| pend_clr | output | 32 | One-cycle strobes to clear pending bits |

## Verification
The hardest state to reach is a stalled output beat with several unmasked vectors queued behind it. The order in which they drain then has to be observed. The bench holds `msg_ready` low and fires one vector so that it occupies the output. While it is stuck, the bench raises several higher and lower vectors in the same cycle. It then accepts one beat at a time and reads each vector back from the low data bits, with the data word's low bits set to zero. A variant drops the enable while a beat is stuck and a second request is queued. This shows the presented beat survives while the queued request is discarded.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msi_msg_t;

  // Replace the low 'mme' bits of the base data word with vector bits.
  function automatic logic [15:0] fold_vector(input logic [15:0] base,
                                              input logic [2:0]  mme,
                                              input logic [15:0] vec);
    logic [15:0] low_mask;
    low_mask = (16'd1 << mme) - 16'd1;
    return (base & ~low_mask) | (vec & low_mask);
  endfunction

endpackage

// File: rtl/msi_req_track.sv
module msi_req_track #(
  parameter int NUM_VEC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic [NUM_VEC-1:0] resend_req,
  input  logic [NUM_VEC-1:0] pending_in,
  input  logic [NUM_VEC-1:0] mask,
  input  logic [NUM_VEC-1:0] grant_oh,
  output logic [NUM_VEC-1:0] cand,
  output logic [NUM_VEC-1:0] pend_set
);

  logic [NUM_VEC-1:0] line_q;
  logic [NUM_VEC-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= irq_req;
  end

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic fresh;
    assign fresh = (irq_req[v] & ~line_q[v]) | (resend_req[v] & pending_in[v]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held_q[v] <= 1'b0;
      else if (!enable) held_q[v] <= 1'b0;
      else              held_q[v] <= (held_q[v] & ~mask[v] & ~grant_oh[v]) | fresh;
    end

    assign cand[v]     = held_q[v] & ~mask[v] & enable;
    assign pend_set[v] = held_q[v] &  mask[v] & enable;
  end

  // A granted vector must have been a held candidate.
  p_grant_from_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_oh & ~held_q) == '0));

endmodule

// File: rtl/msi_lowest_pick.sv
module msi_lowest_pick #(
  parameter int NUM_VEC = 32,
  parameter int IDX_W   = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] cand,
  output logic [NUM_VEC-1:0] pick_oh,
  output logic [IDX_W-1:0]   pick_idx,
  output logic               any
);

  assign pick_oh = cand & (~cand + NUM_VEC'(1));
  assign any     = |cand;

  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (pick_oh[i]) pick_idx = pick_idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/msi_msg_build.sv
module msi_msg_build #(
  parameter int IDX_W = 5
) (
  input  logic              is64,
  input  logic [2:0]        mme,
  input  logic [31:0]       addr_lo,
  input  logic [31:0]       addr_hi,
  input  logic [15:0]       data,
  input  logic [IDX_W-1:0]  vec_idx,
  output msi_pkg::msi_msg_t msg
);

  always_comb begin
    msg.addr = is64 ? {addr_hi, addr_lo} : {32'h0, addr_lo};
    msg.data = {16'h0, msi_pkg::fold_vector(data, mme, 16'(vec_idx))};
  end

endmodule

// File: rtl/msi_out_stage.sv
module msi_out_stage (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  msi_pkg::msi_msg_t msg_in,
  input  logic              ready,
  output logic              valid,
  output msi_pkg::msi_msg_t msg_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      msg_out <= '0;
    end else if (load) begin
      valid   <= 1'b1;
      msg_out <= msg_in;
    end else if (ready) begin
      valid   <= 1'b0;
    end
  end

  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(msg_out)));

  p_no_load_over_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |-> !load);

endmodule

// File: rtl/msi_dispatch.sv
module msi_dispatch #(
  parameter int NUM_VEC = 32,
  localparam int IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic [NUM_VEC-1:0] resend_req,
  input  logic               cfg_enable,
  input  logic               cfg_is64,
  input  logic [2:0]         cfg_mme,
  input  logic [31:0]        cfg_addr_lo,
  input  logic [31:0]        cfg_addr_hi,
  input  logic [15:0]        cfg_data,
  input  logic [NUM_VEC-1:0] cfg_mask,
  input  logic [NUM_VEC-1:0] cfg_pending,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data,
  output logic [NUM_VEC-1:0] pend_set,
  output logic [NUM_VEC-1:0] pend_clr
);

  logic [NUM_VEC-1:0] cand;
  logic [NUM_VEC-1:0] pick_oh;
  logic [NUM_VEC-1:0] grant_oh;
  logic [IDX_W-1:0]   pick_idx;
  logic               any;
  logic               load;
  msi_pkg::msi_msg_t  built;
  msi_pkg::msi_msg_t  held_msg;

  msi_req_track #(.NUM_VEC(NUM_VEC)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (cfg_enable),
    .irq_req    (irq_req),
    .resend_req (resend_req),
    .pending_in (cfg_pending),
    .mask       (cfg_mask),
    .grant_oh   (grant_oh),
    .cand       (cand),
    .pend_set   (pend_set)
  );

  msi_lowest_pick #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_pick (
    .cand     (cand),
    .pick_oh  (pick_oh),
    .pick_idx (pick_idx),
    .any      (any)
  );

  assign load     = cfg_enable & any & (~msg_valid | msg_ready);
  assign grant_oh = load ? pick_oh : '0;
  assign pend_clr = grant_oh;

  msi_msg_build #(.IDX_W(IDX_W)) u_build (
    .is64    (cfg_is64),
    .mme     (cfg_mme),
    .addr_lo (cfg_addr_lo),
    .addr_hi (cfg_addr_hi),
    .data    (cfg_data),
    .vec_idx (pick_idx),
    .msg     (built)
  );

  msi_out_stage u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .msg_in  (built),
    .ready   (msg_ready),
    .valid   (msg_valid),
    .msg_out (held_msg)
  );

  assign msg_addr = held_msg.addr;
  assign msg_data = held_msg.data;

  p_set_clr_disjoint_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_set & pend_clr) == '0));

  p_one_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_clr));

  p_clear_then_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_clr) |=> msg_valid);

  p_data_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_data[31:16] == 16'h0));

  p_disabled_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && !msg_valid) |=> !msg_valid);

  p_lowest_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (((pick_oh - NUM_VEC'(1)) & cand) == '0));

endmodule

// File: tb/tb_msi_dispatch.sv
`timescale 1ns/1ps
module tb_msi_dispatch;

  localparam int NV = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NV-1:0] irq_req, resend_req, cfg_mask, cfg_pending;
  logic          cfg_enable, cfg_is64, msg_ready;
  logic [2:0]    cfg_mme;
  logic [31:0]   cfg_addr_lo, cfg_addr_hi;
  logic [15:0]   cfg_data;
  logic          msg_valid;
  logic [63:0]   msg_addr;
  logic [31:0]   msg_data;
  logic [NV-1:0] pend_set, pend_clr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  msi_dispatch #(.NUM_VEC(NV)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .resend_req(resend_req),
    .cfg_enable(cfg_enable), .cfg_is64(cfg_is64), .cfg_mme(cfg_mme),
    .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi), .cfg_data(cfg_data),
    .cfg_mask(cfg_mask), .cfg_pending(cfg_pending), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data),
    .pend_set(pend_set), .pend_clr(pend_clr)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic accept_one(output int vec, output bit got);
    got = 1'b0;
    vec = -1;
    for (int w = 0; w < 20 && !got; w++) begin
      if (msg_valid) begin
        got = 1'b1;
        vec = int'(msg_data[4:0]);
      end else tick();
    end
    msg_ready = 1'b1;
    tick();
    msg_ready = 1'b0;
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      tick();
      check(!msg_valid && pend_clr == '0, tag, {31'h0, msg_valid, pend_clr}, 64'h0);
    end
  endtask

  task automatic t_reset();
    check(msg_valid == 1'b0, "R7 reset valid", 64'(msg_valid), 64'h0);
    check(pend_set == '0 && pend_clr == '0, "R7 reset strobes",
          {pend_set, pend_clr}, 64'h0);
  endtask

  task automatic t_basic_32();
    cfg_enable = 1; cfg_is64 = 0; cfg_mme = 3'd0; cfg_data = 16'hA5C3;
    cfg_addr_lo = 32'hFEE0_1000; cfg_addr_hi = 32'h0000_1234; msg_ready = 0;
    irq_req[3] = 1'b1;
    tick();
    check(pend_clr == 32'h8 && !msg_valid, "R3 clear strobe before valid",
          {pend_clr, 31'h0, msg_valid}, {32'h8, 32'h0});
    tick();
    check(msg_valid, "R11 valid one edge later", 64'(msg_valid), 64'h1);
    check(msg_addr == 64'h0000_0000_FEE0_1000, "R4 32-bit address", msg_addr,
          64'h0000_0000_FEE0_1000);
    check(msg_data == 32'h0000_A5C3, "R5 data mme0", 64'(msg_data), 64'hA5C3);
    tick();
    check(msg_valid && msg_data == 32'h0000_A5C3, "R7 held while stalled",
          64'(msg_data), 64'hA5C3);
    msg_ready = 1;
    tick();
    msg_ready = 0;
    check(!msg_valid, "R7 drop after accept", 64'(msg_valid), 64'h0);
    irq_req[3] = 1'b0;
    quiet(3, "R1 falling edge silent");
    check(pend_set == '0, "R1 no pending set on fall", 64'(pend_set), 64'h0);
  endtask

  task automatic t_64bit();
    int v; bit got;
    cfg_is64 = 1; cfg_addr_hi = 32'h0000_00AB; cfg_addr_lo = 32'hFEE0_2000;
    cfg_data = 16'h1234; cfg_mme = 3'd3;
    irq_req[13] = 1'b1;
    tick(); tick();
    check(msg_addr == 64'h0000_00AB_FEE0_2000, "R4 64-bit address", msg_addr,
          64'h0000_00AB_FEE0_2000);
    check(msg_data == 32'h0000_1235, "R5 mme3 vector13", 64'(msg_data), 64'h1235);
    accept_one(v, got);
    irq_req[13] = 1'b0;
    tick();
    cfg_mme = 3'd5;
    irq_req[13] = 1'b1;
    tick(); tick();
    check(msg_data == 32'h0000_122D, "R5 mme5 vector13", 64'(msg_data), 64'h122D);
    accept_one(v, got);
    irq_req[13] = 1'b0;
    tick();
  endtask

  task automatic t_masked();
    cfg_is64 = 0; cfg_mme = 3'd5; cfg_data = 16'h4000;
    cfg_mask = 32'h0000_0080;
    irq_req[7] = 1'b1;
    tick();
    check(pend_set == 32'h80 && pend_clr == '0, "R2 masked sets pending",
          {pend_set, pend_clr}, {32'h80, 32'h0});
    tick();
    check(pend_set == '0 && !msg_valid, "R2 single strobe no message",
          {pend_set, 31'h0, msg_valid}, 64'h0);
    quiet(2, "R2 masked stays silent");
    irq_req[7] = 1'b0;
    tick();
  endtask

  task automatic t_resend();
    int v; bit got;
    cfg_mask = '0; cfg_pending = 32'h80;
    resend_req[7] = 1'b1;
    tick();
    resend_req[7] = 1'b0;
    check(pend_clr == 32'h80, "R10 resend clears pending", 64'(pend_clr), 64'h80);
    tick();
    check(msg_valid && msg_data == 32'h0000_4007, "R10 resend message vector 7",
          64'(msg_data), 64'h4007);
    accept_one(v, got);
    cfg_pending = '0;
    resend_req[7] = 1'b1;
    tick();
    resend_req[7] = 1'b0;
    check(pend_clr == '0, "R10 resend without pending ignored", 64'(pend_clr), 64'h0);
    quiet(3, "R10 no message without pending");
  endtask

  task automatic t_stall_order();
    int v; bit got;
    int exp_q[4] = '{9, 2, 20, 30};
    msg_ready = 0;
    irq_req[9] = 1'b1;
    tick(); tick();
    irq_req[2] = 1'b1; irq_req[20] = 1'b1; irq_req[30] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check(msg_valid && msg_data == 32'h0000_4009, "R7 stable during stall",
            64'(msg_data), 64'h4009);
    end
    for (int i = 0; i < 4; i++) begin
      accept_one(v, got);
      check(got && v == exp_q[i], "R9 R8 drain order", 64'(v), 64'(exp_q[i]));
    end
    quiet(3, "R8 nothing extra after drain");
    irq_req = '0;
    tick();
  endtask

  task automatic t_disabled();
    int v; bit got;
    cfg_enable = 0;
    irq_req[4] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      check(!msg_valid && pend_set == '0 && pend_clr == '0, "R6 disabled silent",
            {pend_set, pend_clr}, 64'h0);
    end
    cfg_enable = 1;
    quiet(3, "R6 edge while disabled lost");
    irq_req[4] = 1'b0;
    msg_ready = 0;
    irq_req[1] = 1'b1;
    tick();
    irq_req[2] = 1'b1;
    tick();
    cfg_enable = 0;
    tick();
    cfg_enable = 1;
    accept_one(v, got);
    check(got && v == 1, "R7 presented beat survives disable", 64'(v), 64'h1);
    quiet(4, "R6 held request discarded");
    irq_req = '0;
    tick();
  endtask

  initial begin
    rst_n = 0; irq_req = '0; resend_req = '0; cfg_mask = '0; cfg_pending = '0;
    cfg_enable = 0; cfg_is64 = 0; msg_ready = 0; cfg_mme = '0;
    cfg_addr_lo = '0; cfg_addr_hi = '0; cfg_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    tick();
    t_basic_32();
    t_64bit();
    t_masked();
    t_resend();
    t_stall_order();
    t_disabled();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule